// File: doc/BRIEF.md
# Per-Bit Access-Typed Register File

This block is a small bank of byte-wide registers shared between a CPU and surrounding logic. Each bit of each register carries its own access type, fixed at build time: read-write, clear-on-read, read-only, write-only, live pass-through (no storage), or unused. The CPU reaches a register through an address taken from a constant map that may leave holes. Read data comes back one clock after the read request. The logic side can load any register in one cycle, feeds the live bits, and sees every register's contents on a wide output bus.

Typical use: status flags that the logic raises and software collects with one read (clear-on-read), configuration that software writes and the logic consumes (write-only or read-write), and counters or pin levels shown to software without a flop of their own (live).

The bank has no state machine. Every stored bit is one flop with a fixed priority of sources: logic update first, then CPU write, then the clear caused by a CPU read.

Top module: `regbank_top`

## Requirements
- R1: While `rst_n` is low, stored bits take their reset values (register 3 bits 3:0 = 4'h5, register 5 = 8'hC3, all other stored bits 0), and `cpu_rd_data` is 0.
- R2: Addresses 8'h10, 8'h11, 8'h12, 8'h20, 8'h21 and 8'h22 select registers 0 to 5. A write to any other address changes no register, and a read of any other address returns 0.
- R3: Read-write bits (all of register 0, register 3 bits 3:0) store CPU write data and return it on a read.
- R4: Clear-on-read bits (register 1 bits 3:0) return their value on a read and are zero from the next cycle on. CPU writes do not change them.
- R5: Read-only bits (register 1 bits 7:4, all of register 5) return their stored value on a read and ignore CPU writes.
- R6: Write-only bits (all of register 2) store CPU writes, which are visible on `regs_out`, and read as 0.
- R7: Live bits (all of register 4, register 3 bit 7) have no storage. A read returns `live_in` as it was at the sampling edge, and `regs_out` follows `live_in` directly.
- R8: Unused bits (register 3 bits 6:4) read as 0, show 0 on `regs_out` and ignore writes.
- R9: When `upd_en[i]` is high at an edge, every stored bit of register i takes `upd_data[8i+7:8i]`. This wins over a CPU write to the same register in the same cycle.
- R10: When a logic update and a CPU read of a clear-on-read bit fall in the same cycle, the updated value is kept and the read-clear is dropped.
- R11: `cpu_rd_data` changes only at an edge where `cpu_rd_en` is high, and it shows contents from before that edge. A read and a write to the same address in the same cycle return the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 8 | CPU register address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr_en | input | 1 | CPU write strobe, one cycle per write |
| cpu_rd_en | input | 1 | CPU read strobe, one cycle per read |
| cpu_rd_data | output | 8 | Registered read data |
| upd_en | input | 6 | Logic update enable, one bit per register |
| upd_data | input | 48 | Logic update data, register i in bits 8i+7:8i |
| live_in | input | 48 | Live values for pass-through bits, same layout |
| regs_out | output | 48 | Contents of all registers, same layout |

## Verification
Directed steps first try each access type on its own: write then read back, a read-only write attempt, a double read of the clear-on-read flags, a write-only readback, and a live read with a changed input. Each of these tells a correct type apart from a neighbouring one that has the wrong mask. Directed collisions follow: update against write, update against read-clear, and read against write at the same address. They separate the intended priority from its reversals. A long random run then mixes mapped, hole and arbitrary addresses with sparse updates and changing live values. Every cycle it compares both the read data and the full register bus with a reference model, so decode errors and stray writes show up.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int REG_COUNT = 6;
    localparam int REG_W     = 8;
    localparam int ADDR_W    = 8;

    typedef enum logic [2:0] {
        ACC_RW   = 3'd0,
        ACC_COR  = 3'd1,
        ACC_RO   = 3'd2,
        ACC_WO   = 3'd3,
        ACC_RT   = 3'd4,
        ACC_NONE = 3'd5
    } acc_t;

    // Access type of bit b in register r.
    function automatic acc_t bit_access(input int r, input int b);
        case (r)
            0:       return ACC_RW;
            1:       return (b < 4) ? ACC_COR : ACC_RO;
            2:       return ACC_WO;
            3:       return (b == 7) ? ACC_RT : ((b >= 4) ? ACC_NONE : ACC_RW);
            4:       return ACC_RT;
            5:       return ACC_RO;
            default: return ACC_NONE;
        endcase
    endfunction

    // CPU address of register r; the map is sparse.
    function automatic logic [ADDR_W-1:0] reg_addr(input int r);
        case (r)
            0:       return 8'h10;
            1:       return 8'h11;
            2:       return 8'h12;
            3:       return 8'h20;
            4:       return 8'h21;
            5:       return 8'h22;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] reg_reset(input int r);
        case (r)
            3:       return 8'h05;
            5:       return 8'hC3;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit cpu_writable(input acc_t a);
        return (a == ACC_RW) || (a == ACC_WO);
    endfunction

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
    import regbank_pkg::*;
#(
    parameter int NREGS = REG_COUNT,
    parameter int AW    = ADDR_W
) (
    input  logic [AW-1:0]    addr,
    output logic [NREGS-1:0] hit,
    output logic             mapped
);

    for (genvar i = 0; i < NREGS; i++) begin : g_match
        localparam logic [AW-1:0] MY_ADDR = AW'(reg_addr(i));
        assign hit[i] = (addr == MY_ADDR);
    end

    assign mapped = |hit;

endmodule

// File: rtl/regbank_cell.sv
module regbank_cell
    import regbank_pkg::*;
#(
    parameter int IDX = 0,
    parameter int DW  = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_wr,
    input  logic          cpu_rd,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          upd_en,
    input  logic [DW-1:0] upd_data,
    input  logic [DW-1:0] live,
    output logic [DW-1:0] view,
    output logic [DW-1:0] rd_view
);

    localparam logic [DW-1:0] RST_VAL = DW'(reg_reset(IDX));

    for (genvar b = 0; b < DW; b++) begin : g_bit
        localparam acc_t ACC = bit_access(IDX, b);

        if (ACC == ACC_RT) begin : g_live
            assign view[b]    = live[b];
            assign rd_view[b] = live[b];
        end else if (ACC == ACC_NONE) begin : g_none
            assign view[b]    = 1'b0;
            assign rd_view[b] = 1'b0;
        end else begin : g_store
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= RST_VAL[b];
                end else if (upd_en) begin
                    q <= upd_data[b];
                end else if (cpu_wr && cpu_writable(ACC)) begin
                    q <= cpu_wdata[b];
                end else if (cpu_rd && (ACC == ACC_COR)) begin
                    q <= 1'b0;
                end
            end
            assign view[b]    = q;
            assign rd_view[b] = (ACC == ACC_WO) ? 1'b0 : q;
        end
    end

    logic unused_inputs;
    assign unused_inputs = ^{cpu_wdata, upd_data, live, cpu_rd, cpu_wr, upd_en};

endmodule

// File: rtl/regbank_rdport.sv
module regbank_rdport #(
    parameter int NREGS = 6,
    parameter int DW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [NREGS-1:0]    hit,
    input  logic [NREGS*DW-1:0] rd_views,
    output logic [DW-1:0]       rd_data
);

    logic [DW-1:0] sel;

    always_comb begin
        sel = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (hit[i]) begin
                sel = sel | rd_views[i*DW +: DW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= sel;
        end
    end

endmodule

// File: rtl/regbank_top.sv
module regbank_top
    import regbank_pkg::*;
#(
    parameter int NREGS = REG_COUNT,
    parameter int DW    = REG_W,
    parameter int AW    = ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       cpu_addr,
    input  logic [DW-1:0]       cpu_wdata,
    input  logic                cpu_wr_en,
    input  logic                cpu_rd_en,
    output logic [DW-1:0]       cpu_rd_data,
    input  logic [NREGS-1:0]    upd_en,
    input  logic [NREGS*DW-1:0] upd_data,
    input  logic [NREGS*DW-1:0] live_in,
    output logic [NREGS*DW-1:0] regs_out
);

    logic [NREGS-1:0]    addr_hit;
    logic                addr_mapped;
    logic [NREGS*DW-1:0] rd_views;

    regbank_decode #(.NREGS(NREGS), .AW(AW)) u_decode (
        .addr   (cpu_addr),
        .hit    (addr_hit),
        .mapped (addr_mapped)
    );

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        regbank_cell #(.IDX(i), .DW(DW)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .cpu_wr    (cpu_wr_en && addr_hit[i]),
            .cpu_rd    (cpu_rd_en && addr_hit[i]),
            .cpu_wdata (cpu_wdata),
            .upd_en    (upd_en[i]),
            .upd_data  (upd_data[i*DW +: DW]),
            .live      (live_in[i*DW +: DW]),
            .view      (regs_out[i*DW +: DW]),
            .rd_view   (rd_views[i*DW +: DW])
        );
    end

    regbank_rdport #(.NREGS(NREGS), .DW(DW)) u_rdport (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (cpu_rd_en),
        .hit      (addr_hit),
        .rd_views (rd_views),
        .rd_data  (cpu_rd_data)
    );

    logic unused_mapped;
    assign unused_mapped = addr_mapped;

endmodule

// File: rtl/regbank_checker.sv
module regbank_checker #(
    parameter int NREGS = 6,
    parameter int DW    = 8,
    parameter int AW    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [AW-1:0]       cpu_addr,
    input logic                cpu_rd_en,
    input logic [DW-1:0]       cpu_rd_data,
    input logic [NREGS-1:0]    upd_en,
    input logic [NREGS*DW-1:0] upd_data,
    input logic [NREGS*DW-1:0] regs_out,
    input logic [NREGS-1:0]    addr_hit,
    input logic                addr_mapped
);

    assert_unmapped_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_en && !addr_mapped) |=> (cpu_rd_data == '0));

    assert_cor_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_en && addr_hit[1] && !upd_en[1]) |=> (regs_out[DW +: 4] == 4'h0));

    assert_ro_ignores_cpu_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en[5] |=> $stable(regs_out[5*DW +: DW]));

    assert_wo_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_en && addr_hit[2]) |=> (cpu_rd_data == '0));

    assert_update_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en[0] |=> (regs_out[0 +: DW] == $past(upd_data[0 +: DW])));

    assert_update_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_en && addr_hit[1] && upd_en[1]) |=> (regs_out[DW +: DW] == $past(upd_data[DW +: DW])));

    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd_en |=> $stable(cpu_rd_data));

    logic unused_chk;
    assign unused_chk = ^cpu_addr;

endmodule

bind regbank_top regbank_checker #(.NREGS(NREGS), .DW(DW), .AW(AW)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_addr    (cpu_addr),
    .cpu_rd_en   (cpu_rd_en),
    .cpu_rd_data (cpu_rd_data),
    .upd_en      (upd_en),
    .upd_data    (upd_data),
    .regs_out    (regs_out),
    .addr_hit    (addr_hit),
    .addr_mapped (addr_mapped)
);

// File: tb/regbank_top_bench.sv
`timescale 1ns/1ps
module regbank_top_bench;

    localparam int CLK_PERIOD = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr_en = 1'b0;
    logic        cpu_rd_en = 1'b0;
    logic [7:0]  cpu_rd_data;
    logic [5:0]  upd_en = '0;
    logic [47:0] upd_data = '0;
    logic [47:0] live_in = '0;
    logic [47:0] regs_out;

    int checks = 0;
    int failures = 0;

    logic [7:0] mdl [6];
    logic [7:0] exp_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    regbank_top u_regbank_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_addr    (cpu_addr),
        .cpu_wdata   (cpu_wdata),
        .cpu_wr_en   (cpu_wr_en),
        .cpu_rd_en   (cpu_rd_en),
        .cpu_rd_data (cpu_rd_data),
        .upd_en      (upd_en),
        .upd_data    (upd_data),
        .live_in     (live_in),
        .regs_out    (regs_out)
    );

    // Bit types from the requirements: 0 rw, 1 clear-on-read, 2 ro, 3 wo, 4 live, 5 unused
    function automatic int bt(int r, int b);
        case (r)
            0: return 0;
            1: return (b < 4) ? 1 : 2;
            2: return 3;
            3: return (b == 7) ? 4 : ((b >= 4) ? 5 : 0);
            4: return 4;
            default: return 2;
        endcase
    endfunction

    function automatic logic [7:0] addr_of(int r);
        logic [7:0] t [6] = '{8'h10, 8'h11, 8'h12, 8'h20, 8'h21, 8'h22};
        return t[r];
    endfunction

    function automatic logic [47:0] exp_bus(logic [47:0] lv);
        logic [47:0] v = '0;
        for (int r = 0; r < 6; r++) begin
            for (int b = 0; b < 8; b++) begin
                case (bt(r, b))
                    4:       v[r*8+b] = lv[r*8+b];
                    5:       v[r*8+b] = 1'b0;
                    default: v[r*8+b] = mdl[r][b];
                endcase
            end
        end
        return v;
    endfunction

    task automatic check(string tag, logic [47:0] act, logic [47:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // One cycle: entered at a falling edge, left at the next one after checking.
    task automatic step(string tag, bit wr, bit rd, logic [7:0] a, logic [7:0] wd,
                        logic [5:0] ue, logic [47:0] ud, logic [47:0] lv);
        int hit_r;
        logic [7:0] nxt [6];
        cpu_wr_en = wr; cpu_rd_en = rd; cpu_addr = a; cpu_wdata = wd;
        upd_en = ue; upd_data = ud; live_in = lv;
        hit_r = -1;
        for (int r = 0; r < 6; r++) if (addr_of(r) == a) hit_r = r;
        if (rd) begin
            exp_rd = '0;
            if (hit_r >= 0) begin
                for (int b = 0; b < 8; b++) begin
                    case (bt(hit_r, b))
                        0, 1, 2: exp_rd[b] = mdl[hit_r][b];
                        4:       exp_rd[b] = lv[hit_r*8+b];
                        default: exp_rd[b] = 1'b0;
                    endcase
                end
            end
        end
        for (int r = 0; r < 6; r++) begin
            nxt[r] = mdl[r];
            for (int b = 0; b < 8; b++) begin
                if (ue[r]) nxt[r][b] = ud[r*8+b];
                else if (wr && hit_r == r && (bt(r, b) == 0 || bt(r, b) == 3)) nxt[r][b] = wd[b];
                else if (rd && hit_r == r && bt(r, b) == 1) nxt[r][b] = 1'b0;
            end
        end
        @(posedge clk);
        for (int r = 0; r < 6; r++) mdl[r] = nxt[r];
        @(negedge clk);
        check({tag, " rd_data"}, {40'd0, cpu_rd_data}, {40'd0, exp_rd});
        check({tag, " regs_out"}, regs_out, exp_bus(lv));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] r64a, r64b;
        logic [7:0] ra;
        void'($urandom(32'd20240607));
        mdl[0] = 8'h00; mdl[1] = 8'h00; mdl[2] = 8'h00;
        mdl[3] = 8'h05; mdl[4] = 8'h00; mdl[5] = 8'hC3;
        exp_rd = 8'h00;
        repeat (3) @(negedge clk);
        check("R1 reset rd_data", {40'd0, cpu_rd_data}, 48'd0);
        check("R1 reset regs_out", regs_out, exp_bus(48'd0));
        rst_n = 1'b1;

        // R3 read-write
        step("R3 write r0", 1, 0, 8'h10, 8'hA5, 0, 0, 0);
        step("R3 read r0", 0, 1, 8'h10, 8'h00, 0, 0, 0);
        // R6 write-only
        step("R6 write r2", 1, 0, 8'h12, 8'h3C, 0, 0, 0);
        step("R6 read r2", 0, 1, 8'h12, 8'h00, 0, 0, 0);
        // R5 read-only
        step("R5 write r5", 1, 0, 8'h22, 8'hFF, 0, 0, 0);
        step("R5 read r5", 0, 1, 8'h22, 8'h00, 0, 0, 0);
        // R4 clear-on-read after logic load
        step("R9 load r1", 0, 0, 8'h00, 8'h00, 6'b000010, 48'h0000_0000_9F00, 0);
        step("R4 first read r1", 0, 1, 8'h11, 8'h00, 0, 0, 0);
        step("R4 second read r1", 0, 1, 8'h11, 8'h00, 0, 0, 0);
        step("R4 write ignored r1", 1, 0, 8'h11, 8'h0F, 0, 0, 0);
        step("R4 read after write r1", 0, 1, 8'h11, 8'h00, 0, 0, 0);
        // R7 and R8 on register 3
        step("R8 write r3", 1, 0, 8'h20, 8'hFF, 0, 0, 0);
        step("R8 read r3", 0, 1, 8'h20, 8'h00, 0, 0, 48'h0000_0000_0000);
        step("R7 read r3 live", 0, 1, 8'h20, 8'h00, 0, 0, 48'h0000_8000_0000);
        step("R7 read r4 live", 0, 1, 8'h21, 8'h00, 0, 0, 48'h006E_0000_0000);
        step("R11 hold with live change", 0, 0, 8'h21, 8'h00, 0, 0, 48'h0011_0000_0000);
        // R2 unmapped
        step("R2 write hole", 1, 0, 8'h30, 8'hFF, 0, 0, 0);
        step("R2 read hole", 0, 1, 8'h30, 8'h00, 0, 0, 0);
        step("R2 write 0x13", 1, 1, 8'h13, 8'hFF, 0, 0, 0);
        // R9 update beats write
        step("R9 update vs write", 1, 0, 8'h10, 8'h11, 6'b000001, 48'h0000_0000_0077, 0);
        step("R9 read r0", 0, 1, 8'h10, 8'h00, 0, 0, 0);
        // R10 update beats read-clear
        step("R10 load r1", 0, 0, 8'h00, 8'h00, 6'b000010, 48'h0000_0000_0A00, 0);
        step("R10 update vs clear", 0, 1, 8'h11, 8'h00, 6'b000010, 48'h0000_0000_0500, 0);
        step("R10 read r1", 0, 1, 8'h11, 8'h00, 0, 0, 0);
        // R11 read with write same address returns old
        step("R11 read+write r0", 1, 1, 8'h10, 8'h42, 0, 0, 0);
        step("R11 read r0 new", 0, 1, 8'h10, 8'h00, 0, 0, 0);

        // Random mix (R2, R3, R4, R5, R6, R7, R9, R11)
        for (int n = 0; n < 800; n++) begin
            case ($urandom % 8)
                6:       ra = 8'h30;
                7:       ra = 8'($urandom);
                default: ra = addr_of(int'($urandom % 6));
            endcase
            r64a = {$urandom, $urandom};
            r64b = {$urandom, $urandom};
            step("R11 random", bit'($urandom % 2), bit'($urandom % 2), ra, 8'($urandom),
                 (($urandom % 4) == 0) ? 6'($urandom) : 6'd0, r64a[47:0], r64b[47:0]);
        end

        // R1 reset again restores values
        @(negedge clk);
        rst_n = 1'b0;
        mdl[0] = 8'h00; mdl[1] = 8'h00; mdl[2] = 8'h00;
        mdl[3] = 8'h05; mdl[4] = 8'h00; mdl[5] = 8'hC3;
        @(negedge clk);
        check("R1 reset again rd_data", {40'd0, cpu_rd_data}, 48'd0);
        check("R1 reset again regs_out", regs_out, exp_bus(live_in));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule